// File: doc/BRIEF.md
# Hot-Plug I/O Expander Manager

This block keeps the hot-plug signals of a set of downstream slots consistent with an external I/O expander on a two-wire bus, so that the slot controls and slot status need no dedicated pins. It holds two shadow images. The output image carries per-slot controls such as power enable, indicators and slot reset. The input image carries per-slot status such as presence, attention button and power fault. Any change to an output slot causes one bus write of the complete output image. An active-low level from the expander's interrupt line causes one bus read of the complete input image.

The two-wire bit engine is shared with the configuration loader. The block therefore asks for it with a request/grant handshake. While the request is high, the block presents the device address, a register code, a read/write flag and the write data. It then waits for a done strobe and an error flag. Nothing is issued until configuration loading has reported completion. A failed transaction is retried a bounded number of times. After that, a sticky error flag is raised.

The control is one state machine with six states:
- WAIT_CFG goes to IDLE once configuration is done.
- IDLE goes to WRITE when a write is pending. Otherwise it goes to READ when the interrupt is low.
- WRITE and READ end on a granted done strobe.
- A failed attempt goes to BACKOFF and then re-enters the same transfer state, unless the retry budget is spent.
- A finished write returns to IDLE.
- A finished read, successful or not, passes through SETTLE before IDLE.

Top module: `hpx_mgr`

## Requirements
- R1: After reset, bus_req, exp_out, exp_in, in_chg and err_flag are all zero. No bus request is raised before cfg_done has been seen high. Output updates made during that time are still stored in exp_out and are written out afterwards.
- R2: A pulse on slot_out_we[s] that changes slot s's field in exp_out (bits s*OUT_PER_SLOT upward) updates exp_out on the next edge. It also causes exactly one write: bus_rw=0, bus_reg=OUT_REG, bus_wdata carrying the complete output image. A pulse that repeats the stored value issues no transfer.
- R3: A low level on exp_int_n, after a SYNC_STAGES-flop synchronizer, causes one read: bus_rw=1, bus_reg=IN_REG. A successful read loads bus_rdata into exp_in. exp_in changes on no other event.
- R4: When a read succeeds, in_chg[s] is high for exactly one cycle for each slot s whose field in the returned data differs from its previous exp_in field. It stays low for every other slot.
- R5: The interrupt is level-sensitive. After any read, the block waits SYNC_STAGES cycles in SETTLE. It then issues another read if the line is still low, and issues none if the line has gone high.
- R6: When an output write and an interrupt read are both pending, the write is issued first.
- R7: Output changes made while a write is in flight are merged into a single follow-up write that carries the latest output image.
- R8: A transfer that ends with bus_err set drops bus_req for one cycle. It is then reissued with the same fields, up to MAX_RETRY more times.
- R9: When the final allowed attempt fails, err_flag is set and stays set until reset. A failed read leaves exp_in unchanged and raises no in_chg bit.
- R10: Once raised, bus_req stays high, with bus_rw and bus_wdata stable, until a cycle in which bus_gnt and bus_done are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Configuration loading complete |
| slot_out_we | input | NSLOT | Per-slot output update strobe |
| slot_out_val | input | NSLOT*OUT_PER_SLOT | New per-slot output values |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| bus_req | output | 1 | Request for the shared two-wire master |
| bus_gnt | input | 1 | Master granted to this block |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dev | output | 7 | Expander device address |
| bus_reg | output | 8 | Expander register code |
| bus_wdata | output | DW | Write data (full output image) |
| bus_rdata | input | DW | Read data (full input image) |
| bus_done | input | 1 | Transfer finished strobe |
| bus_err | input | 1 | Transfer failed, valid with bus_done |
| exp_out | output | NSLOT*OUT_PER_SLOT | Output shadow image |
| exp_in | output | NSLOT*IN_PER_SLOT | Input shadow image |
| in_chg | output | NSLOT | Per-slot input change pulse |
| err_flag | output | 1 | Sticky transfer failure flag |

## Verification
The bench builds the block with three slots of three bits in each direction. This gives nine-bit images that do not fit a byte, and it keeps MAX_RETRY at 3 and SYNC_STAGES at 2. With these values, four failed attempts are enough to exhaust the retry budget. Each slot field is small enough that the change pulses of different slots can be told apart, and the settle window is short enough that a stale synchronizer value would show up as a spurious second read.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_CFG = 3'd0,
        ST_IDLE     = 3'd1,
        ST_WRITE    = 3'd2,
        ST_READ     = 3'd3,
        ST_BACKOFF  = 3'd4,
        ST_SETTLE   = 3'd5
    } hpx_state_t;

    typedef enum logic {
        OP_WR = 1'b0,
        OP_RD = 1'b1
    } hpx_op_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hpx_sync.sv
module hpx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hpx_out_shadow.sv
module hpx_out_shadow #(
    parameter int NSLOT   = 4,
    parameter int PER     = 4,
    parameter int W       = NSLOT * PER,
    parameter logic [W-1:0] RST_IMG = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] we,
    input  logic [W-1:0]     val,
    output logic [W-1:0]     img,
    output logic             changed
);
    logic [NSLOT-1:0] diff;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign diff[s] = we[s] && (val[s*PER +: PER] != img[s*PER +: PER]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                img[s*PER +: PER] <= RST_IMG[s*PER +: PER];
            end else if (we[s]) begin
                img[s*PER +: PER] <= val[s*PER +: PER];
            end
        end

        // R2: a slot field moves only when its strobe was high
        a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !we[s] |=> $stable(img[s*PER +: PER]));
    end

    assign changed = |diff;
endmodule

// File: rtl/hpx_in_shadow.sv
module hpx_in_shadow #(
    parameter int NSLOT   = 4,
    parameter int PER     = 4,
    parameter int W       = NSLOT * PER,
    parameter logic [W-1:0] RST_IMG = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     rdata,
    output logic [W-1:0]     img,
    output logic [NSLOT-1:0] chg
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                img[s*PER +: PER] <= RST_IMG[s*PER +: PER];
                chg[s]            <= 1'b0;
            end else begin
                chg[s] <= load && (rdata[s*PER +: PER] != img[s*PER +: PER]);
                if (load) begin
                    img[s*PER +: PER] <= rdata[s*PER +: PER];
                end
            end
        end
    end

    // R4: change pulses only follow a successful read load
    a_r4_chg_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |-> $past(load));
endmodule

// File: rtl/hpx_seq.sv
module hpx_seq
    import hpx_pkg::*;
#(
    parameter int DW         = 16,
    parameter int MAX_RETRY  = 3,
    parameter int SETTLE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_done,
    input  logic          wr_change,
    input  logic          int_low,
    input  logic [DW-1:0] out_img,
    input  logic          bus_gnt,
    input  logic          bus_done,
    input  logic          bus_err,
    output logic          bus_req,
    output logic          bus_rw,
    output logic [DW-1:0] wdata,
    output logic          rd_load,
    output logic          err_flag
);
    localparam int TW = $clog2(MAX_RETRY + 1);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    hpx_state_t       state, nxt;
    hpx_op_t          op_q;
    logic             pend_q;
    logic [TW-1:0]    tries_q;
    logic [CW-1:0]    settle_q;
    logic [DW-1:0]    wdata_q;
    logic             err_q;
    logic             xfer_end;
    logic             last_try;
    logic             settle_end;

    assign xfer_end   = bus_req && bus_gnt && bus_done;
    assign last_try   = (tries_q == TW'(MAX_RETRY));
    assign settle_end = (settle_q == CW'(SETTLE_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_CFG;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_CFG: if (cfg_done) nxt = ST_IDLE;
            ST_IDLE: begin
                if (pend_q)       nxt = ST_WRITE;
                else if (int_low) nxt = ST_READ;
            end
            ST_WRITE: begin
                if (xfer_end) begin
                    if (bus_err && !last_try) nxt = ST_BACKOFF;
                    else                      nxt = ST_IDLE;
                end
            end
            ST_READ: begin
                if (xfer_end) begin
                    if (bus_err && !last_try) nxt = ST_BACKOFF;
                    else                      nxt = ST_SETTLE;
                end
            end
            ST_BACKOFF: nxt = (op_q == OP_RD) ? ST_READ : ST_WRITE;
            ST_SETTLE:  if (settle_end) nxt = ST_IDLE;
            default:    nxt = ST_WAIT_CFG;
        endcase
    end

    // outputs and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_WR;
            pend_q   <= 1'b0;
            tries_q  <= '0;
            settle_q <= '0;
            wdata_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && pend_q) begin
                pend_q <= wr_change;
            end else if (wr_change) begin
                pend_q <= 1'b1;
            end

            if (state == ST_IDLE) begin
                if (pend_q) begin
                    op_q    <= OP_WR;
                    wdata_q <= out_img;
                    tries_q <= '0;
                end else if (int_low) begin
                    op_q    <= OP_RD;
                    tries_q <= '0;
                end
            end

            if (xfer_end && bus_err) begin
                if (last_try) err_q   <= 1'b1;
                else          tries_q <= tries_q + 1'b1;
            end

            if (state == ST_SETTLE) settle_q <= settle_q + 1'b1;
            else                    settle_q <= '0;
        end
    end

    assign bus_req  = (state == ST_WRITE) || (state == ST_READ);
    assign bus_rw   = (state == ST_READ);
    assign wdata    = wdata_q;
    assign rd_load  = (state == ST_READ) && xfer_end && !bus_err;
    assign err_flag = err_q;

    // R10: request and its fields hold until the granted done strobe
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !(bus_gnt && bus_done) |=> bus_req && $stable(bus_rw) && $stable(wdata));

    // R8: the request drops for at least one cycle after every transfer end
    a_r8_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && bus_done |=> !bus_req);

    // R9: the error flag never clears without reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

// File: rtl/hpx_mgr.sv
module hpx_mgr
    import hpx_pkg::*;
#(
    parameter int NSLOT        = 4,
    parameter int OUT_PER_SLOT = 4,
    parameter int IN_PER_SLOT  = 4,
    parameter int MAX_RETRY    = 3,
    parameter int SYNC_STAGES  = 2,
    parameter logic [6:0] DEV_ADDR = 7'h27,
    parameter logic [7:0] OUT_REG  = 8'h02,
    parameter logic [7:0] IN_REG   = 8'h00,
    localparam int OUT_W = NSLOT * OUT_PER_SLOT,
    localparam int IN_W  = NSLOT * IN_PER_SLOT,
    localparam int DW    = max_int(OUT_W, IN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done,
    input  logic [NSLOT-1:0] slot_out_we,
    input  logic [OUT_W-1:0] slot_out_val,
    input  logic             exp_int_n,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             bus_rw,
    output logic [6:0]       bus_dev,
    output logic [7:0]       bus_reg,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_done,
    input  logic             bus_err,
    output logic [OUT_W-1:0] exp_out,
    output logic [IN_W-1:0]  exp_in,
    output logic [NSLOT-1:0] in_chg,
    output logic             err_flag
);
    logic          int_n_s;
    logic          int_low;
    logic          wr_change;
    logic          rd_load;
    logic [DW-1:0] img_ext;
    logic          cfg_seen_q;

    hpx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(exp_int_n), .q(int_n_s)
    );
    assign int_low = !int_n_s;

    hpx_out_shadow #(.NSLOT(NSLOT), .PER(OUT_PER_SLOT)) u_out (
        .clk(clk), .rst_n(rst_n), .we(slot_out_we), .val(slot_out_val),
        .img(exp_out), .changed(wr_change)
    );

    always_comb begin
        img_ext = '0;
        img_ext[OUT_W-1:0] = exp_out;
    end

    hpx_seq #(.DW(DW), .MAX_RETRY(MAX_RETRY), .SETTLE_CYC(SYNC_STAGES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .wr_change(wr_change),
        .int_low(int_low), .out_img(img_ext), .bus_gnt(bus_gnt),
        .bus_done(bus_done), .bus_err(bus_err), .bus_req(bus_req),
        .bus_rw(bus_rw), .wdata(bus_wdata), .rd_load(rd_load),
        .err_flag(err_flag)
    );

    hpx_in_shadow #(.NSLOT(NSLOT), .PER(IN_PER_SLOT)) u_in (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .rdata(bus_rdata[IN_W-1:0]),
        .img(exp_in), .chg(in_chg)
    );

    assign bus_dev = DEV_ADDR;
    assign bus_reg = bus_rw ? IN_REG : OUT_REG;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_seen_q <= 1'b0;
        else if (cfg_done) cfg_seen_q <= 1'b1;
    end

    // R1: no bus traffic before configuration loading has finished
    a_r1_no_req_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cfg_seen_q);

    // R3: the input image changes only on a successful granted read
    a_r3_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_rw && bus_gnt && bus_done && !bus_err) |=> $stable(exp_in));
endmodule

// File: tb/hpx_mgr_test.sv
module hpx_mgr_test;
    localparam int NS = 3;
    localparam int PS = 3;
    localparam int W  = NS * PS;
    localparam logic [7:0] OREG = 8'h02;
    localparam logic [7:0] IREG = 8'h00;

    typedef struct packed {
        logic [1:0]   slot;
        logic [2:0]   val;
        logic         wr;
        logic [W-1:0] img;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd1, 3'b011, 1'b1, 9'h01D},
        '{2'd1, 3'b011, 1'b0, 9'h01D},
        '{2'd2, 3'b110, 1'b1, 9'h19D},
        '{2'd0, 3'b101, 1'b0, 9'h19D},
        '{2'd0, 3'b000, 1'b1, 9'h198},
        '{2'd2, 3'b001, 1'b1, 9'h058}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_done = 1'b0;
    logic [NS-1:0] slot_out_we = '0;
    logic [W-1:0]  slot_out_val = '0;
    logic exp_int_n = 1'b1;
    logic bus_req, bus_rw;
    logic bus_gnt = 1'b0, bus_done = 1'b0, bus_err = 1'b0;
    logic [6:0] bus_dev;
    logic [7:0] bus_reg;
    logic [W-1:0] bus_wdata;
    logic [W-1:0] bus_rdata = '0;
    logic [W-1:0] exp_out, exp_in;
    logic [NS-1:0] in_chg;
    logic err_flag;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hpx_mgr #(.NSLOT(NS), .OUT_PER_SLOT(PS), .IN_PER_SLOT(PS), .MAX_RETRY(3),
              .SYNC_STAGES(2), .OUT_REG(OREG), .IN_REG(IREG)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .slot_out_we(slot_out_we),
        .slot_out_val(slot_out_val), .exp_int_n(exp_int_n), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_rw(bus_rw), .bus_dev(bus_dev), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
        .bus_err(bus_err), .exp_out(exp_out), .exp_in(exp_in), .in_chg(in_chg),
        .err_flag(err_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic apply_update(input int slot, input logic [2:0] val);
        @(negedge clk);
        slot_out_we[slot] = 1'b1;
        slot_out_val[slot*PS +: PS] = val;
        @(negedge clk);
        slot_out_we = '0;
    endtask

    task automatic wait_req(input string req, output logic rw,
                            output logic [W-1:0] wd, output logic [7:0] rg);
        logic ok = 1'b0;
        rw = 1'b0; wd = '0; rg = '0;
        for (int i = 0; i < 200 && !ok; i++) begin
            @(negedge clk);
            if (bus_req) begin
                ok = 1'b1; rw = bus_rw; wd = bus_wdata; rg = bus_reg;
                bus_gnt = 1'b1;
            end
        end
        check({req, " request seen"}, 32'(ok), 32'd1);
    endtask

    task automatic finish_xfer(input logic err, input logic [W-1:0] rd,
                               input logic release_int, output logic [NS-1:0] chg,
                               output logic req_after);
        @(negedge clk);
        bus_done = 1'b1; bus_err = err; bus_rdata = rd;
        if (release_int) exp_int_n = 1'b1;
        @(negedge clk);
        bus_done = 1'b0; bus_err = 1'b0; bus_gnt = 1'b0;
        chg = in_chg; req_after = bus_req;
    endtask

    task automatic expect_idle(input string req, input int n);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_req) seen = 1'b1;
        end
        check({req, " no request"}, 32'(seen), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin : main
        logic rw, rq;
        logic [W-1:0] wd;
        logic [7:0] rg;
        logic [NS-1:0] chg;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 reset req", 32'(bus_req), 0);
        check("R1 reset exp_out", 32'(exp_out), 0);
        check("R1 reset exp_in", 32'(exp_in), 0);
        check("R1 reset err_flag", 32'(err_flag), 0);
        check("R1 reset in_chg", 32'(in_chg), 0);
        check("R1 device address", 32'(bus_dev), 32'h27);
        rst_n = 1'b1;

        // R1 nothing issued before configuration completes
        apply_update(0, 3'b101);
        check("R1 shadow before cfg", 32'(exp_out), 32'h005);
        exp_int_n = 1'b0;
        expect_idle("R1 before cfg", 20);

        // R6 pending write goes before the pending read
        @(negedge clk);
        cfg_done = 1'b1;
        wait_req("R6 first", rw, wd, rg);
        check("R6 first is write", 32'(rw), 0);
        check("R2 write data", 32'(wd), 32'h005);
        check("R2 write reg", 32'(rg), 32'(OREG));
        finish_xfer(1'b0, '0, 1'b0, chg, rq);
        wait_req("R3 read", rw, wd, rg);
        check("R3 read rw", 32'(rw), 1);
        check("R3 read reg", 32'(rg), 32'(IREG));
        finish_xfer(1'b0, 9'h101, 1'b1, chg, rq);
        check("R4 change pulse", 32'(chg), 32'b101);
        check("R3 input image", 32'(exp_in), 32'h101);
        @(negedge clk);
        check("R4 pulse one cycle", 32'(in_chg), 0);
        expect_idle("R5 released", 12);

        // R2 table of output updates
        for (int i = 0; i < 6; i++) begin
            apply_update(int'(VEC[i].slot), VEC[i].val);
            check("R2 image", 32'(exp_out), 32'(VEC[i].img));
            if (VEC[i].wr) begin
                wait_req("R2 vec", rw, wd, rg);
                check("R2 vec rw", 32'(rw), 0);
                check("R2 vec data", 32'(wd), 32'(VEC[i].img));
                finish_xfer(1'b0, '0, 1'b0, chg, rq);
            end else begin
                expect_idle("R2 same value", 10);
            end
        end

        // R7 merge during in-flight write, R6 write before read
        apply_update(0, 3'b111);
        wait_req("R7 first", rw, wd, rg);
        check("R7 first data", 32'(wd), 32'h05F);
        apply_update(1, 3'b100);
        apply_update(2, 3'b010);
        exp_int_n = 1'b0;
        finish_xfer(1'b0, '0, 1'b0, chg, rq);
        wait_req("R7 merged", rw, wd, rg);
        check("R6 write before read", 32'(rw), 0);
        check("R7 merged data", 32'(wd), 32'h0A7);
        finish_xfer(1'b0, '0, 1'b0, chg, rq);
        wait_req("R6 then read", rw, wd, rg);
        check("R6 read after write", 32'(rw), 1);
        finish_xfer(1'b0, 9'h101, 1'b1, chg, rq);
        check("R4 no change", 32'(chg), 0);
        expect_idle("R7 single follow-up", 12);

        // R5 level held low gives a second read
        exp_int_n = 1'b0;
        wait_req("R5 read1", rw, wd, rg);
        finish_xfer(1'b0, 9'h141, 1'b0, chg, rq);
        check("R4 slot2 change", 32'(chg), 32'b100);
        wait_req("R5 reread", rw, wd, rg);
        check("R5 reread rw", 32'(rw), 1);
        finish_xfer(1'b0, 9'h141, 1'b1, chg, rq);
        check("R4 same data no pulse", 32'(chg), 0);
        expect_idle("R5 released", 12);

        // R8 retries with identical fields
        apply_update(1, 3'b111);
        for (int i = 0; i < 3; i++) begin
            wait_req("R8 attempt", rw, wd, rg);
            check("R8 same data", 32'(wd), 32'h0BF);
            finish_xfer(i < 2, '0, 1'b0, chg, rq);
            if (i < 2) check("R8 req dropped", 32'(rq), 0);
        end
        check("R8 no error after recovery", 32'(err_flag), 0);
        expect_idle("R8 done", 10);

        // R9 read retries exhausted
        exp_int_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            wait_req("R9 attempt", rw, wd, rg);
            check("R9 is read", 32'(rw), 1);
            finish_xfer(1'b1, 9'h1FF, i == 3, chg, rq);
            check("R9 no change pulse", 32'(chg), 0);
        end
        check("R9 err set", 32'(err_flag), 1);
        check("R9 input image kept", 32'(exp_in), 32'h141);
        expect_idle("R9 gave up", 12);

        // R9 sticky through a later good write
        apply_update(0, 3'b000);
        wait_req("R9 later", rw, wd, rg);
        check("R2 later data", 32'(wd), 32'h0B8);
        finish_xfer(1'b0, '0, 1'b0, chg, rq);
        check("R9 still set", 32'(err_flag), 1);

        // R1/R9 reset clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears err", 32'(err_flag), 0);
        check("R1 reset clears out", 32'(exp_out), 0);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule